// File: doc/BRIEF.md
# Four-Plane Graphics Write Datapath

This block is the processor-side data path of a video memory built from four byte-wide bit planes. One processor byte written to an address becomes four plane bytes at that address. The byte may be rotated, combined with four read latches through a logic function, replaced by per-plane fill colours, or spread out by bit position, and is then merged with the latches under a bit mask. A separate plane-enable mask decides which planes are actually written. A read loads all four plane bytes into the latches. It returns either one chosen plane or a colour-match bitmap over the eight pixels at that address.

Control state lives in nine internal registers reached through one byte-wide port: a write with `cfg_sel_i` low sets the register index, and a write with `cfg_sel_i` high writes the indexed register. The plane storage is a simple reset-cleared array inside the block.

Top module: `planar_write_path`

## Requirements
- R1: After reset, every plane byte is 0x00, `cpu_rdata_o` is 0x00 and `cpu_rvalid_o` is 0. The registers reset to: bit mask 0xFF, plane enable 0xF, care mask 0xF, and 0 everywhere else.
- R2: Register indices are: 0 fill colour [3:0], 1 fill enable [3:0], 2 compare colour [3:0], 3 operation (rotate [2:0], function [4:3]), 4 read plane [1:0], 5 mode (write mode [1:0], compare enable [3]), 6 care mask [3:0], 7 bit mask [7:0], 8 plane enable [3:0]. A data write while the index is 9 to 15 changes nothing.
- R3: In write modes 0 and 3 the processor byte is first rotated right by the rotate count.
- R4: Function 00 passes the source byte, 01 ANDs it with the plane latch, 10 ORs it, 11 XORs it.
- R5: In write mode 0, a plane whose fill-enable bit is 1 uses its fill-colour bit copied to all 8 bits as the source; the other planes use the rotated byte.
- R6: In write mode 1, each plane receives its latch byte unchanged, whatever the function and the bit mask.
- R7: In write mode 2, plane n receives bit n of the unrotated processor byte copied to all 8 bits, before function and mask.
- R8: In write mode 3, each plane's source is its fill-colour bit copied to all 8 bits, and the effective mask is the rotated byte ANDed with the bit mask.
- R9: In modes 0, 2 and 3, bit positions where the mask is 0 take the latch value.
- R10: A plane whose plane-enable bit is 0 keeps its stored byte on a write.
- R11: A read loads all four latches with the plane bytes at the address. `cpu_rdata_o` and a one-cycle `cpu_rvalid_o` pulse appear on the clock edge after the read request.
- R12: With compare enable set, bit i of the read result is 1 when, for every plane n whose care bit is 1, bit i of plane n equals compare colour bit n. A care mask of 0 yields 0xFF.
- R13: With compare enable clear, a read returns the plane selected by the read-plane field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control port write strobe |
| cfg_sel_i | input | 1 | 0 selects the index, 1 selects the indexed register |
| cfg_wdata_i | input | 8 | Control port write byte |
| cpu_we_i | input | 1 | Processor write request |
| cpu_re_i | input | 1 | Processor read request |
| cpu_addr_i | input | AW | Byte address within each plane |
| cpu_wdata_i | input | 8 | Processor write byte |
| cpu_rdata_o | output | 8 | Read result, registered |
| cpu_rvalid_o | output | 1 | Read result valid for one cycle |

## Verification
On every cycle, the assertions check four things: mask-protected bit positions keep the latch value after a write, a mode-1 write stores exactly the latches, disabled planes never change, and a read loads the latches and produces one valid pulse. They also check that a data write to an unused index leaves the registers alone, and that an empty care mask gives an all-ones match. Only the bench scenarios can show the actual data values, because those depend on combinations of state. They cover the rotate amount, each function code against a known latch, fill-colour substitution, the mode-2 spread of bits and the mode-3 mask built from the data, and the match bitmaps for chosen colours and care masks.

// File: rtl/vgw_pkg.sv
package vgw_pkg;
  localparam int unsigned NPLANES = 4;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned NREGS   = 9;

  typedef enum logic [1:0] {WM_DIRECT, WM_LATCH, WM_EXPAND, WM_FILL} wmode_e;
  typedef enum logic [1:0] {FN_PASS, FN_AND, FN_OR, FN_XOR} fn_e;

  typedef struct packed {
    logic [3:0] fill_val;
    logic [3:0] fill_en;
    logic [3:0] cmp_color;
    logic [2:0] rot;
    fn_e        fn;
    logic [1:0] rd_plane;
    wmode_e     wmode;
    logic       cmp_en;
    logic [3:0] care;
    logic [7:0] bit_mask;
    logic [3:0] plane_en;
  } cfg_t;
endpackage

// File: rtl/vgw_regs.sv
module vgw_regs
  import vgw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic       cfg_sel_i,
  input  logic [7:0] cfg_wdata_i,
  output cfg_t       cfg_o
);
  logic [IDX_W-1:0] idx_q;
  cfg_t             cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q          <= '0;
      cfg_q          <= '0;
      cfg_q.care     <= 4'hF;
      cfg_q.bit_mask <= 8'hFF;
      cfg_q.plane_en <= 4'hF;
    end else if (cfg_we_i) begin
      if (!cfg_sel_i) begin
        idx_q <= cfg_wdata_i[IDX_W-1:0];
      end else begin
        case (idx_q)
          4'd0: cfg_q.fill_val  <= cfg_wdata_i[3:0];
          4'd1: cfg_q.fill_en   <= cfg_wdata_i[3:0];
          4'd2: cfg_q.cmp_color <= cfg_wdata_i[3:0];
          4'd3: begin
            cfg_q.rot <= cfg_wdata_i[2:0];
            cfg_q.fn  <= fn_e'(cfg_wdata_i[4:3]);
          end
          4'd4: cfg_q.rd_plane  <= cfg_wdata_i[1:0];
          4'd5: begin
            cfg_q.wmode  <= wmode_e'(cfg_wdata_i[1:0]);
            cfg_q.cmp_en <= cfg_wdata_i[3];
          end
          4'd6: cfg_q.care      <= cfg_wdata_i[3:0];
          4'd7: cfg_q.bit_mask  <= cfg_wdata_i;
          4'd8: cfg_q.plane_en  <= cfg_wdata_i[3:0];
          default: ;
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;

  // R2: unused indices are write-ignored
  p_bad_index_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i && (idx_q >= IDX_W'(NREGS))) |=> $stable(cfg_q));
endmodule

// File: rtl/vgw_plane_alu.sv
module vgw_plane_alu
  import vgw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  wmode_e        wmode_i,
  input  fn_e           fn_i,
  input  logic [DW-1:0] rot_data_i,
  input  logic          cpu_bit_i,
  input  logic          fill_bit_i,
  input  logic          fill_en_i,
  input  logic [DW-1:0] latch_i,
  input  logic [DW-1:0] bit_mask_i,
  output logic [DW-1:0] wdata_o
);
  logic [DW-1:0] src, alu, mask;

  always_comb begin
    unique case (wmode_i)
      WM_DIRECT: src = fill_en_i ? {DW{fill_bit_i}} : rot_data_i;
      WM_EXPAND: src = {DW{cpu_bit_i}};
      default:   src = {DW{fill_bit_i}};
    endcase
    unique case (fn_i)
      FN_AND:  alu = src & latch_i;
      FN_OR:   alu = src | latch_i;
      FN_XOR:  alu = src ^ latch_i;
      default: alu = src;
    endcase
    unique case (wmode_i)
      WM_FILL:  mask = rot_data_i & bit_mask_i;
      WM_LATCH: mask = '0;
      default:  mask = bit_mask_i;
    endcase
    wdata_o = (alu & mask) | (latch_i & ~mask);
  end
endmodule

// File: rtl/vgw_read_mux.sv
module vgw_read_mux
  import vgw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] plane_i [NPLANES],
  input  logic          cmp_en_i,
  input  logic [3:0]    color_i,
  input  logic [3:0]    care_i,
  input  logic [1:0]    sel_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] match;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic [NPLANES-1:0] pix;
    for (genvar p = 0; p < NPLANES; p++) begin : g_pl
      assign pix[p] = plane_i[p][b];
    end
    assign match[b] = ~|((pix ^ color_i) & care_i);
  end

  assign rdata_o = cmp_en_i ? match : plane_i[sel_i];

  // R12: an empty care mask matches every pixel
  p_empty_care_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && care_i == 4'h0) |-> (rdata_o == {DW{1'b1}}));
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
  import vgw_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [7:0]    cfg_wdata_i,
  input  logic          cpu_we_i,
  input  logic          cpu_re_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          cpu_rvalid_o
);
  localparam int unsigned DEPTH = 1 << AW;

  cfg_t          cfg;
  logic [DW-1:0] mem_q   [NPLANES][DEPTH];
  logic [DW-1:0] latch_q [NPLANES];
  logic [DW-1:0] cur     [NPLANES];
  logic [DW-1:0] wdata   [NPLANES];
  logic [DW-1:0] rot_data, rd_val, rdata_q;
  logic          rvalid_q;

  vgw_regs i_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .cfg_o(cfg)
  );

  assign rot_data = DW'({cpu_wdata_i, cpu_wdata_i} >> cfg.rot);

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    assign cur[p] = mem_q[p][cpu_addr_i];

    vgw_plane_alu #(.DW(DW)) i_alu (
      .wmode_i    (cfg.wmode),
      .fn_i       (cfg.fn),
      .rot_data_i (rot_data),
      .cpu_bit_i  (cpu_wdata_i[p]),
      .fill_bit_i (cfg.fill_val[p]),
      .fill_en_i  (cfg.fill_en[p]),
      .latch_i    (latch_q[p]),
      .bit_mask_i (cfg.bit_mask),
      .wdata_o    (wdata[p])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int a = 0; a < DEPTH; a++) mem_q[p][a] <= '0;
        latch_q[p] <= '0;
      end else begin
        if (cpu_we_i && cfg.plane_en[p]) mem_q[p][cpu_addr_i] <= wdata[p];
        if (cpu_re_i) latch_q[p] <= cur[p];
      end
    end

    // R10: disabled plane is untouched
    p_plane_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_we_i && !cfg.plane_en[p]) |=>
        (mem_q[p][$past(cpu_addr_i)] == $past(mem_q[p][cpu_addr_i])));
    // R9: positions outside the bit mask keep the latch
    p_mask_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_we_i && cfg.plane_en[p] && cfg.wmode != WM_LATCH) |=>
        (((mem_q[p][$past(cpu_addr_i)] ^ $past(latch_q[p])) & ~$past(cfg.bit_mask)) == '0));
    // R6: mode 1 stores the latch
    p_latch_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_we_i && cfg.plane_en[p] && cfg.wmode == WM_LATCH) |=>
        (mem_q[p][$past(cpu_addr_i)] == $past(latch_q[p])));
    // R11: a read loads the latch
    p_latch_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_re_i |=> (latch_q[p] == $past(cur[p])));
  end

  vgw_read_mux #(.DW(DW)) i_rmux (
    .clk_i, .rst_ni,
    .plane_i  (cur),
    .cmp_en_i (cfg.cmp_en),
    .color_i  (cfg.cmp_color),
    .care_i   (cfg.care),
    .sel_i    (cfg.rd_plane),
    .rdata_o  (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cpu_re_i;
      if (cpu_re_i) rdata_q <= rd_val;
    end
  end

  assign cpu_rdata_o  = rdata_q;
  assign cpu_rvalid_o = rvalid_q;

  // R11: one valid pulse per read request
  p_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_re_i |=> cpu_rvalid_o);
  p_no_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_re_i |=> !cpu_rvalid_o);
endmodule

// File: tb/test_planar_write_path.sv
`timescale 1ns/1ps
module test_planar_write_path;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [7:0]    cfg_wdata_i = '0;
  logic          cpu_we_i = 1'b0, cpu_re_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [7:0]    cpu_wdata_i = '0;
  logic [7:0]    cpu_rdata_o;
  logic          cpu_rvalid_o;

  planar_write_path #(.DW(8), .AW(AW)) i_planar_write_path (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  logic [7:0] q_val[$];
  string      q_tag[$];

  // reference state
  logic [7:0] m_mem [4][DEPTH];
  logic [7:0] m_lat [4];
  logic [3:0] r_fv = 0, r_fe = 0, r_cc = 0, r_care = 4'hF, r_pe = 4'hF;
  logic [2:0] r_rot = 0;
  logic [1:0] r_fn = 0, r_rp = 0, r_wm = 0;
  logic       r_ce = 0;
  logic [7:0] r_bm = 8'hFF;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && cpu_rvalid_o) begin
      if (q_val.size() == 0) check("R11 spurious rvalid", 8'h01, 8'h00);
      else check(q_tag.pop_front(), cpu_rdata_o, q_val.pop_front());
    end
  end

  task automatic cfg(logic [7:0] idx, logic [7:0] val);
    cfg_we_i = 1; cfg_sel_i = 0; cfg_wdata_i = idx;
    @(negedge clk_i);
    cfg_sel_i = 1; cfg_wdata_i = val;
    @(negedge clk_i);
    cfg_we_i = 0;
    case (idx)
      0: r_fv = val[3:0];
      1: r_fe = val[3:0];
      2: r_cc = val[3:0];
      3: begin r_rot = val[2:0]; r_fn = val[4:3]; end
      4: r_rp = val[1:0];
      5: begin r_wm = val[1:0]; r_ce = val[3]; end
      6: r_care = val[3:0];
      7: r_bm = val;
      8: r_pe = val[3:0];
      default: ;
    endcase
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    logic [15:0] dd = {d, d};
    logic [7:0] rot = dd[r_rot +: 8];
    for (int p = 0; p < 4; p++) begin
      logic [7:0] src, alu, msk;
      case (r_wm)
        0: src = r_fe[p] ? {8{r_fv[p]}} : rot;
        2: src = {8{d[p]}};
        default: src = {8{r_fv[p]}};
      endcase
      case (r_fn)
        1: alu = src & m_lat[p];
        2: alu = src | m_lat[p];
        3: alu = src ^ m_lat[p];
        default: alu = src;
      endcase
      msk = (r_wm == 1) ? 8'h00 : (r_wm == 3) ? (rot & r_bm) : r_bm;
      if (r_pe[p]) m_mem[p][a] = (alu & msk) | (m_lat[p] & ~msk);
    end
    cpu_we_i = 1; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_we_i = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    logic [7:0] e;
    if (r_ce) begin
      for (int b = 0; b < 8; b++) begin
        logic ok = 1;
        for (int p = 0; p < 4; p++)
          if (r_care[p] && m_mem[p][a][b] != r_cc[p]) ok = 0;
        e[b] = ok;
      end
    end else e = m_mem[r_rp][a];
    for (int p = 0; p < 4; p++) m_lat[p] = m_mem[p][a];
    q_val.push_back(e); q_tag.push_back(tag);
    cpu_re_i = 1; cpu_addr_i = a;
    @(negedge clk_i);
    cpu_re_i = 0;
  endtask

  task automatic rd_all(logic [AW-1:0] a, string tag);
    for (int p = 0; p < 4; p++) begin
      cfg(4, 8'(p));
      rd(a, tag);
    end
  endtask

  bit timed_out = 0;
  initial begin
    #(20 * 100000);
    timed_out = 1;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      m_lat[p] = 0;
      for (int a = 0; a < DEPTH; a++) m_mem[p][a] = 0;
    end
    repeat (3) @(negedge clk_i);
    check("R1 rdata reset", cpu_rdata_o, 8'h00);
    check("R1 rvalid reset", {7'd0, cpu_rvalid_o}, 8'h00);
    rst_ni = 1;
    @(negedge clk_i);
    rd_all(4'd0, "R1 plane reset");

    wr(4'd1, 8'hA5);                       // mode 0 pass, no rotate
    rd_all(4'd1, "R13 plane select");

    cfg(3, 8'h03);                         // R3 rotate by 3
    wr(4'd2, 8'h81);
    rd_all(4'd2, "R3 rotate right");

    cfg(3, 8'h00); wr(4'd3, 8'h0F);
    rd(4'd3, "R4 setup");
    cfg(3, 8'h08); wr(4'd3, 8'h3C);        // AND
    rd_all(4'd3, "R4 and");
    cfg(3, 8'h10); wr(4'd3, 8'hC3);        // OR
    rd_all(4'd3, "R4 or");
    cfg(3, 8'h18); wr(4'd3, 8'hFF);        // XOR
    rd_all(4'd3, "R4 xor");

    cfg(3, 8'h00); cfg(0, 8'h05); cfg(1, 8'h03);
    wr(4'd4, 8'h77);
    rd_all(4'd4, "R5 fill substitution");

    cfg(1, 8'h00); cfg(7, 8'hF0);
    rd(4'd4, "R9 setup");
    wr(4'd4, 8'h00);
    rd_all(4'd4, "R9 bit mask");

    cfg(5, 8'h01); cfg(3, 8'h18); cfg(7, 8'h0F);
    rd(4'd1, "R6 setup");
    wr(4'd5, 8'h3C);
    rd_all(4'd5, "R6 latch copy");

    cfg(5, 8'h02); cfg(3, 8'h02); cfg(7, 8'hFF);
    wr(4'd6, 8'h0A);
    rd_all(4'd6, "R7 expand");

    cfg(5, 8'h03); cfg(3, 8'h01); cfg(0, 8'h0A); cfg(7, 8'h3C);
    rd(4'd1, "R8 setup");
    wr(4'd7, 8'hE1);
    rd_all(4'd7, "R8 fill mode");

    cfg(5, 8'h00); cfg(3, 8'h00); cfg(7, 8'hFF); cfg(8, 8'h05);
    wr(4'd1, 8'hFF);
    rd_all(4'd1, "R10 plane enable");
    cfg(8, 8'h0F);

    cfg(5, 8'h02); cfg(7, 8'h0F);
    rd(4'd9, "R12 setup");
    wr(4'd9, 8'h05);
    rd(4'd9, "R12 setup");
    cfg(7, 8'hF0);
    wr(4'd9, 8'h03);
    cfg(5, 8'h08);
    cfg(2, 8'h05); rd(4'd9, "R12 colour 5");
    cfg(2, 8'h03); rd(4'd9, "R12 colour 3");
    cfg(2, 8'h01); cfg(6, 8'h01); rd(4'd9, "R12 care subset");
    cfg(6, 8'h00); rd(4'd9, "R12 empty care");
    cfg(2, 8'h07); cfg(6, 8'h0F); rd(4'd9, "R12 no match");

    cfg(5, 8'h00); cfg(7, 8'hFF);
    cfg(8'd12, 8'h00);                     // R2: unused index
    wr(4'd10, 8'h5A);
    rd_all(4'd10, "R2 unused index ignored");

    cfg(4, 8'h00);
    rd(4'd2, "R11 back to back");
    rd(4'd3, "R11 back to back");
    @(negedge clk_i);
    check("R11 rvalid drops", {7'd0, cpu_rvalid_o}, 8'h00);
    @(negedge clk_i);
    checks++;
    if (q_val.size() != 0) begin
      failures++;
      $display("FAIL R11 pending reads actual=%0d expected=0", q_val.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge timed_out) begin
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule